// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a 32-bit down-counter that raises a local interrupt request when it runs out. Software reaches it through a small memory-mapped register set: a vector entry, which holds the interrupt vector, a mask bit, the reload mode and a timer-base field; an initial-count register; a read-only current-count register; and a divide-code register. A write to the initial count loads the counter and starts it counting. The counter steps down once every N bus-clock cycles, where N is set by the divide code.

When the count steps from one to zero, the block drives a single-cycle request that carries the programmed vector, unless the entry is masked. In periodic mode the counter reloads from the initial count at that same step and carries on counting. In one-shot mode it stays at zero until software writes the initial count again. Writing an initial count of zero stops the timer.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset, the vector entry reads 0x0001_0000 (only the mask, bit 16, is set). The initial count, current count and divide code all read 0, and irqValid is low.
- R2: The vector entry keeps bits [7:0] (vector), 16 (mask), 17 (mode: 1 = periodic) and [19:18] (timer base), and its other bits read 0. The divide register keeps bits [3:0]. Writes to the current-count offset are ignored. Unmapped offsets read 0. The offsets are: vector entry 0x320, initial count 0x380, current count 0x390, divide code 0x3E0.
- R3: A write of a nonzero value V to the initial count loads the counter with V at that clock edge. The current-count register then returns the live remaining count.
- R4: The counter drops by one every D cycles after the load. D is set by the divide code: 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128, 0xB→1.
- R5: Any divide code not listed in R4 behaves as divide-by-2.
- R6: When the count steps from 1 to 0 (at edge V·D after the load), irqValid is high for the following cycle and irqVector equals the vector field.
- R7: In one-shot mode (bit 17 = 0), the counter stays at zero after it expires and raises no further request.
- R8: In periodic mode, the expiring step reloads the initial count instead of reaching zero. Requests then repeat every V·D cycles, and the current count never reads 0 while the timer runs.
- R9: With the mask bit set, the counter still counts and reloads but never asserts irqValid.
- R10: Writing 0 to the initial count stops the timer. The current count reads 0 and no request follows.
- R11: Every write to the initial count restarts the prescaler, so the first decrement after the write comes exactly D cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector of the current request |

## Verification
The hardest case to reach from the ports is a rewrite of the initial count while the prescaler is partway through a period. Only a write that lands a specific number of cycles after the previous load shows whether the prescaler is restarted. The bench therefore rewrites the count two edges into a divide-by-4 period and checks that the request arrives a full V·D cycles after the second write. Wide divisors are reached by sweeping all sixteen divide codes with a count of one, so each code's period is measured on its own.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes from control to the counting datapath
  typedef struct packed {
    logic load;      // initial-count write this cycle
    logic tick;      // prescaler period complete, counter steps
    logic periodic;  // reload on expiry
    logic masked;    // suppress the request
  } ctrlStrobes_t;

  localparam int SHIFT_W = 3;                 // divider exponent width
  localparam int PRESC_W = (1 << SHIFT_W) - 1; // prescaler counter width
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int COUNT_W   = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter logic [ADDR_W-1:0] LVT_ADDR  = 12'h320,
  parameter logic [ADDR_W-1:0] INIT_ADDR = 12'h380,
  parameter logic [ADDR_W-1:0] CUR_ADDR  = 12'h390,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 12'h3E0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [COUNT_W-1:0] curCount,
  output ctrlStrobes_t       strobes,
  output logic [VEC_W-1:0]   vector,
  output logic [COUNT_W-1:0] initCount,
  output logic [DATA_W-1:0]  rdata
);
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;
  localparam int BASE_LO  = 18;

  logic             maskReg, periodicReg;
  logic [1:0]       baseReg;
  logic [3:0]       divCode;
  logic [PRESC_W-1:0] prescCnt;
  logic [SHIFT_W-1:0] divShift;
  logic [PRESC_W:0]   divisor;
  logic [PRESC_W-1:0] divMinus1;
  logic selLvt, selInit, selDiv, running, prescDone;

  assign selLvt  = wrEn && (addr == LVT_ADDR);
  assign selInit = wrEn && (addr == INIT_ADDR);
  assign selDiv  = wrEn && (addr == DIV_ADDR);

  // Register storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vector      <= '0;
      maskReg     <= 1'b1;
      periodicReg <= 1'b0;
      baseReg     <= 2'b00;
      divCode     <= 4'h0;
      initCount   <= '0;
    end else begin
      if (selLvt) begin
        vector      <= wdata[VEC_W-1:0];
        maskReg     <= wdata[MASK_BIT];
        periodicReg <= wdata[MODE_BIT];
        baseReg     <= wdata[BASE_LO+1:BASE_LO];
      end
      if (selDiv)  divCode   <= wdata[3:0];
      if (selInit) initCount <= wdata[COUNT_W-1:0];
    end
  end

  // Divide code to exponent; codes with bit 2 set fall back to /2
  always_comb begin
    if (divCode[2]) divShift = SHIFT_W'(1);
    else            divShift = SHIFT_W'({divCode[3], divCode[1:0]} + 3'd1);
  end

  assign divisor   = {{PRESC_W{1'b0}}, 1'b1} << divShift;
  assign divMinus1 = divisor[PRESC_W-1:0] - PRESC_W'(1);

  assign running   = (curCount != '0);
  assign prescDone = (prescCnt >= divMinus1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            prescCnt <= '0;
    else if (selInit || !running || prescDone) prescCnt <= '0;
    else                                  prescCnt <= prescCnt + PRESC_W'(1);
  end

  always_comb begin
    strobes.load     = selInit;
    strobes.tick     = running && prescDone && !selInit;
    strobes.periodic = periodicReg;
    strobes.masked   = maskReg;
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      LVT_ADDR: begin
        rdata[VEC_W-1:0]         = vector;
        rdata[MASK_BIT]          = maskReg;
        rdata[MODE_BIT]          = periodicReg;
        rdata[BASE_LO+1:BASE_LO] = baseReg;
      end
      INIT_ADDR: rdata[COUNT_W-1:0] = initCount;
      CUR_ADDR:  rdata[COUNT_W-1:0] = curCount;
      DIV_ADDR:  rdata[3:0]         = divCode;
      default:   rdata = '0;
    endcase
  end

  // R11: an initial-count write leaves the prescaler at its start
  assert_presc_restart_R11: assert property (@(posedge clk) disable iff (!rstN)
    selInit |=> (prescCnt == '0));
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [COUNT_W-1:0] loadValue,
  input  logic [COUNT_W-1:0] initCount,
  input  logic [VEC_W-1:0]   vector,
  output logic [COUNT_W-1:0] count,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector
);
  logic expiring;
  assign expiring = strobes.tick && (count == COUNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid <= 1'b0;
      if (strobes.load) begin
        count <= loadValue;
      end else if (expiring) begin
        count <= strobes.periodic ? initCount : '0;
        if (!strobes.masked) begin
          irqValid  <= 1'b1;
          irqVector <= vector;
        end
      end else if (strobes.tick) begin
        count <= count - COUNT_W'(1);
      end
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && count > COUNT_W'(1)) |=> (count == $past(count) - COUNT_W'(1)));

  assert_irq_after_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(count) == COUNT_W'(1)));

  assert_oneshot_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strobes.load) |=> (count == '0));

  assert_periodic_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.periodic && count != '0 && !strobes.load) |=> (count != '0));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(strobes.masked));
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
  import timer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);
  ctrlStrobes_t       strobes;
  logic [COUNT_W-1:0] curCount;
  logic [COUNT_W-1:0] initCount;
  logic [VEC_W-1:0]   vector;

  timer_ctrl #(
    .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .curCount(curCount), .strobes(strobes), .vector(vector),
    .initCount(initCount), .rdata(rdata)
  );

  timer_datapath #(
    .COUNT_W(COUNT_W), .VEC_W(VEC_W)
  ) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadValue(wdata[COUNT_W-1:0]), .initCount(initCount), .vector(vector),
    .count(curCount), .irqValid(irqValid), .irqVector(irqVector)
  );
endmodule

// File: tb/countdown_irq_timer_test.sv
module countdown_irq_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_LVT  = 12'h320;
  localparam logic [11:0] A_INIT = 12'h380;
  localparam logic [11:0] A_CUR  = 12'h390;
  localparam logic [11:0] A_DIV  = 12'h3E0;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irqValid;
  logic [7:0] irqVector;
  int checks = 0, fails = 0;
  bit finished = 0;

  countdown_irq_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irqValid(irqValid), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    wrEn = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic watch(input int n, output int first, output int hits);
    first = -1; hits = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      if (irqValid) begin hits++; if (first < 0) first = k; end
    end
  endtask

  function automatic int divOf(input int code);
    case (code)
      0: return 2;   1: return 4;   2: return 8;   3: return 16;
      8: return 32;  9: return 64;  10: return 128; 11: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic testReset();
    logic [31:0] d;
    busRead(A_LVT, d);  checkEq("R1", "vector entry", d, 32'h0001_0000);
    busRead(A_INIT, d); checkEq("R1", "initial count", d, 0);
    busRead(A_CUR, d);  checkEq("R1", "current count", d, 0);
    busRead(A_DIV, d);  checkEq("R1", "divide code", d, 0);
    checkEq("R1", "irqValid", irqValid, 0);
  endtask

  task automatic testRegisters();
    logic [31:0] d;
    busWrite(A_LVT, 32'hFFFF_FFFF);
    busRead(A_LVT, d); checkEq("R2", "entry fields", d, 32'h000F_00FF);
    busWrite(A_DIV, 32'hFFFF_FFF4);
    busRead(A_DIV, d); checkEq("R2", "divide bits", d, 32'h4);
    busWrite(A_CUR, 32'h1234);
    busRead(A_CUR, d); checkEq("R2", "current count write ignored", d, 0);
    busRead(12'h300, d); checkEq("R2", "unmapped read", d, 0);
  endtask

  task automatic testOneShot();
    logic [31:0] d; int first, hits;
    busWrite(A_LVT, 32'h0000_0042);
    busWrite(A_DIV, 32'h0);
    busWrite(A_INIT, 32'd3);
    waitEdges(2);
    busRead(A_CUR, d); checkEq("R3", "live count", d, 2);
    waitEdges(4);
    checkEq("R6", "irq at expiry", irqValid, 1);
    checkEq("R6", "vector", irqVector, 8'h42);
    waitEdges(1);
    checkEq("R6", "irq one cycle", irqValid, 0);
    watch(20, first, hits);
    checkEq("R7", "no repeat", hits, 0);
    busRead(A_CUR, d); checkEq("R7", "holds zero", d, 0);
  endtask

  task automatic testDivides();
    int first, hits;
    for (int code = 0; code < 16; code++) begin
      busWrite(A_DIV, 32'(code));
      busWrite(A_INIT, 32'd1);
      watch(divOf(code) + 2, first, hits);
      if (code == 0 || code == 1 || code == 2 || code == 3 ||
          (code >= 8 && code <= 11))
        checkEq("R4", $sformatf("code %0d period", code), first, divOf(code));
      else
        checkEq("R5", $sformatf("code %0d period", code), first, 2);
      checkEq("R4", "single request", hits, 1);
    end
  endtask

  task automatic testPeriodic();
    logic [31:0] d; int first, hits;
    busWrite(A_LVT, 32'h0002_0077);
    busWrite(A_DIV, 32'h0);
    busWrite(A_INIT, 32'd4);
    watch(24, first, hits);
    checkEq("R8", "first request", first, 8);
    checkEq("R8", "request count", hits, 3);
    busRead(A_CUR, d); checkEq("R8", "reloaded count", d, 4);
    busWrite(A_INIT, 32'd0);
    busRead(A_CUR, d); checkEq("R10", "stopped count", d, 0);
    watch(20, first, hits);
    checkEq("R10", "no request after stop", hits, 0);
  endtask

  task automatic testMasked();
    logic [31:0] d; int first, hits;
    busWrite(A_LVT, 32'h0003_0077);
    busWrite(A_DIV, 32'hB);
    busWrite(A_INIT, 32'd3);
    waitEdges(1);
    busRead(A_CUR, d); checkEq("R9", "masked still counts", d, 2);
    watch(10, first, hits);
    checkEq("R9", "masked no request", hits, 0);
    busRead(A_CUR, d); checkEq("R9", "masked reloads", d, 1);
    busWrite(A_INIT, 32'd0);
  endtask

  task automatic testRestart();
    int first, hits;
    busWrite(A_LVT, 32'h0000_0042);
    busWrite(A_DIV, 32'h1);
    busWrite(A_INIT, 32'd2);
    waitEdges(2);
    busWrite(A_INIT, 32'd2);
    watch(12, first, hits);
    checkEq("R11", "request after rewrite", first, 8);
    checkEq("R11", "single request", hits, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    testReset();
    testRegisters();
    testOneShot();
    testDivides();
    testPeriodic();
    testMasked();
    testRestart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule